// File: doc/BRIEF.md
# Radix-4 Complex Butterfly Node

This block is the arithmetic core of one column of a 64-point inverse FFT. Each transfer presents four complex samples and the four complex twiddle factors that belong with them. The node multiplies every sample by its own twiddle, rounds the products back to sample scale, and passes them through a two-level add/subtract network. One branch of that network is rotated by a quarter turn, which is a multiply by j. The four complex results leave the node in a fixed order that the permutation stage after it relies on.

Every complex quantity is a pair of signed 16-bit fixed-point fields, one real and one imaginary. Twiddles use a Q1.15 format. The network grows the word by one guard bit at each level. The final results are divided by four with an arithmetic shift, so they return to 16 bits. A parameter sets whether the results pass through an output register, which has a valid flag one clock later, or leave the node combinationally.

Lane n of a bus occupies bits [16n+15:16n], so lane 0 is in the least significant bits.

Top module: `r4bf_node`

## Requirements
- R1: Each lane product m[n] = k[n]·t[n] uses real = kr·tr − ki·ti and imag = kr·ti + ki·tr. Each part is then rounded as floor((p + 2^14) / 2^15), which is round-half-up at 15 fractional bits.
- R2: The first network level forms y0 = m0 + m2, y1 = m0 − m2 and y2 = m1 + m3, with real and imaginary parts handled independently.
- R3: The first level forms y3 = j·(m1 − m3) without a multiplier. Its real part is the negated imaginary part of the difference, and its imaginary part is the real part of the difference.
- R4: The second level produces output lanes in the order z0 = y0 + y2, z1 = y1 + y3, z2 = y0 − y2 and z3 = y1 − y3.
- R5: Each output field is floor(z / 4), taken modulo 2^16. This value does not wrap when every product part lies in [−32768, 32767].
- R6: With OUT_REG = 1, a transfer accepted while valid_in is high appears on z_re and z_im after the next rising clock edge, and valid_out is high for exactly that one cycle.
- R7: With OUT_REG = 1, z_re and z_im hold their previous values across any clock edge at which valid_in is low.
- R8: With OUT_REG = 1, a synchronous active-high rst drives valid_out, z_re and z_im to zero.
- R9: With OUT_REG = 0, valid_out equals valid_in, and z_re and z_im follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Transfer qualifier for the input lanes |
| t_re | input | 64 | Sample real parts, four lanes |
| t_im | input | 64 | Sample imaginary parts, four lanes |
| k_re | input | 64 | Twiddle real parts, Q1.15, four lanes |
| k_im | input | 64 | Twiddle imaginary parts, Q1.15, four lanes |
| valid_out | output | 1 | Result qualifier |
| z_re | output | 64 | Result real parts, four lanes |
| z_im | output | 64 | Result imaginary parts, four lanes |

## Verification
The only state in the node is the output register and its valid flag. A wrong arithmetic path therefore shows up on the ports in the cycle right after the transfer that exercises it. A wrong captured value or a missed hold is visible on the first idle clock, because the outputs should then stay unchanged. Directed vectors isolate single lanes and lane pairs so that a swapped sign, a misplaced j rotation or a reordered output lands on a distinct output field. A rounding or shift error shows up on operands whose low bits sit at the half-way point or are negative.

// File: rtl/r4bf_pkg.sv
package r4bf_pkg;

    // Sample and twiddle field width
    parameter int unsigned DATA_W = 16;
    // Fractional bits of a twiddle
    parameter int unsigned FRAC_W = 15;
    // Lanes per butterfly
    parameter int unsigned LANES  = 4;

    // Full product width: two DATA_W products summed
    localparam int unsigned PW = 2 * DATA_W + 1;
    // Rounded product width
    localparam int unsigned MW = PW - FRAC_W;
    // First-level width (one guard bit)
    localparam int unsigned YW = MW + 1;
    // Second-level width (one more guard bit)
    localparam int unsigned ZW = YW + 1;
    // Final arithmetic down-scale
    localparam int unsigned OUT_SHIFT = 2;
    localparam int unsigned BUS_W = LANES * DATA_W;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [MW-1:0] re;
        logic signed [MW-1:0] im;
    } prod_t;

    typedef struct packed {
        logic signed [YW-1:0] re;
        logic signed [YW-1:0] im;
    } lvl1_t;

    typedef struct packed {
        logic signed [ZW-1:0] re;
        logic signed [ZW-1:0] im;
    } lvl2_t;

    // Quarter-turn rotation: (a + jb) * j = -b + ja
    function automatic lvl1_t rot_j(input lvl1_t v);
        lvl1_t r;
        r.re = -v.im;
        r.im = v.re;
        return r;
    endfunction

endpackage

// File: rtl/r4bf_cmul.sv
module r4bf_cmul
    import r4bf_pkg::*;
(
    input  samp_t smp,
    input  samp_t twd,
    output prod_t prod
);
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W - 1);

    logic signed [PW-1:0] sr, si, wr, wi;
    logic signed [PW-1:0] acc_re, acc_im;
    logic signed [PW-1:0] rnd_re, rnd_im;

    always_comb begin
        sr = PW'($signed(smp.re));
        si = PW'($signed(smp.im));
        wr = PW'($signed(twd.re));
        wi = PW'($signed(twd.im));
        acc_re = wr * sr - wi * si;
        acc_im = wr * si + wi * sr;
        rnd_re = acc_re + HALF;
        rnd_im = acc_im + HALF;
        prod.re = rnd_re[FRAC_W +: MW];
        prod.im = rnd_im[FRAC_W +: MW];
    end

endmodule

// File: rtl/r4bf_addnet.sv
module r4bf_addnet
    import r4bf_pkg::*;
(
    input  prod_t m [LANES],
    output lvl2_t z [LANES]
);
    lvl1_t y [LANES];
    lvl1_t d13;

    always_comb begin
        y[0].re = YW'($signed(m[0].re)) + YW'($signed(m[2].re));
        y[0].im = YW'($signed(m[0].im)) + YW'($signed(m[2].im));
        y[1].re = YW'($signed(m[0].re)) - YW'($signed(m[2].re));
        y[1].im = YW'($signed(m[0].im)) - YW'($signed(m[2].im));
        y[2].re = YW'($signed(m[1].re)) + YW'($signed(m[3].re));
        y[2].im = YW'($signed(m[1].im)) + YW'($signed(m[3].im));
        d13.re  = YW'($signed(m[1].re)) - YW'($signed(m[3].re));
        d13.im  = YW'($signed(m[1].im)) - YW'($signed(m[3].im));
        y[3]    = rot_j(d13);

        z[0].re = ZW'($signed(y[0].re)) + ZW'($signed(y[2].re));
        z[0].im = ZW'($signed(y[0].im)) + ZW'($signed(y[2].im));
        z[1].re = ZW'($signed(y[1].re)) + ZW'($signed(y[3].re));
        z[1].im = ZW'($signed(y[1].im)) + ZW'($signed(y[3].im));
        z[2].re = ZW'($signed(y[0].re)) - ZW'($signed(y[2].re));
        z[2].im = ZW'($signed(y[0].im)) - ZW'($signed(y[2].im));
        z[3].re = ZW'($signed(y[1].re)) - ZW'($signed(y[3].re));
        z[3].im = ZW'($signed(y[1].im)) - ZW'($signed(y[3].im));
    end

endmodule

// File: rtl/r4bf_outstage.sv
module r4bf_outstage
    import r4bf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  lvl2_t            z [LANES],
    output logic             vld_o,
    output logic [BUS_W-1:0] re_o,
    output logic [BUS_W-1:0] im_o
);
    logic [BUS_W-1:0] re_s, im_s;

    for (genvar n = 0; n < LANES; n++) begin : g_scale
        assign re_s[n*DATA_W +: DATA_W] = z[n].re[OUT_SHIFT +: DATA_W];
        assign im_s[n*DATA_W +: DATA_W] = z[n].im[OUT_SHIFT +: DATA_W];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_o <= 1'b0;
                re_o  <= '0;
                im_o  <= '0;
            end else begin
                vld_o <= vld_i;
                if (vld_i) begin
                    re_o <= re_s;
                    im_o <= im_s;
                end
            end
        end
    end else begin : g_comb
        assign vld_o = vld_i;
        assign re_o  = re_s;
        assign im_o  = im_s;
    end

endmodule

// File: rtl/r4bf_node.sv
module r4bf_node
    import r4bf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [BUS_W-1:0] t_re,
    input  logic [BUS_W-1:0] t_im,
    input  logic [BUS_W-1:0] k_re,
    input  logic [BUS_W-1:0] k_im,
    output logic             valid_out,
    output logic [BUS_W-1:0] z_re,
    output logic [BUS_W-1:0] z_im
);
    samp_t smp [LANES];
    samp_t twd [LANES];
    prod_t m   [LANES];
    lvl2_t z   [LANES];

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign smp[n].re = t_re[n*DATA_W +: DATA_W];
        assign smp[n].im = t_im[n*DATA_W +: DATA_W];
        assign twd[n].re = k_re[n*DATA_W +: DATA_W];
        assign twd[n].im = k_im[n*DATA_W +: DATA_W];

        r4bf_cmul u_mul (
            .smp  (smp[n]),
            .twd  (twd[n]),
            .prod (m[n])
        );
    end

    r4bf_addnet u_net (
        .m (m),
        .z (z)
    );

    r4bf_outstage #(.OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst   (rst),
        .vld_i (valid_in),
        .z     (z),
        .vld_o (valid_out),
        .re_o  (z_re),
        .im_o  (z_im)
    );

endmodule

// File: rtl/r4bf_node_chk.sv
module r4bf_node_chk
    import r4bf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_in,
    input logic [BUS_W-1:0] k_re,
    input logic [BUS_W-1:0] k_im,
    input logic             valid_out,
    input logic [BUS_W-1:0] z_re,
    input logic [BUS_W-1:0] z_im
);
    if (OUT_REG) begin : g_seq
        assert_valid_delay_R6: assert property (@(posedge clk) disable iff (rst)
            valid_out == $past(valid_in));

        assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
            !$past(valid_in) |-> ($stable(z_re) && $stable(z_im)));

        assert_reset_clear_R8: assert property (@(posedge clk)
            $past(rst) |-> (!valid_out && z_re == '0 && z_im == '0));

        assert_zero_twiddle_R1: assert property (@(posedge clk) disable iff (rst)
            ($past(valid_in) && $past(k_re) == '0 && $past(k_im) == '0)
                |-> (z_re == '0 && z_im == '0));
    end else begin : g_cmb
        always_comb begin
            assert_valid_pass_R9: assert (valid_out == valid_in);
        end

        assert_zero_twiddle_comb_R1: assert property (@(posedge clk) disable iff (rst)
            (k_re == '0 && k_im == '0) |-> (z_re == '0 && z_im == '0));
    end

endmodule

bind r4bf_node r4bf_node_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .k_re      (k_re),
    .k_im      (k_im),
    .valid_out (valid_out),
    .z_re      (z_re),
    .z_im      (z_im)
);

// File: tb/tb_r4bf_node.sv
module tb_r4bf_node;
    localparam int L = 4;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_in = 1'b0;
    logic [L*W-1:0] t_re = '0, t_im = '0, k_re = '0, k_im = '0;
    logic           valid_out, valid_out_c;
    logic [L*W-1:0] z_re, z_im, zc_re, zc_im;

    int n_chk  = 0;
    int n_fail = 0;
    logic [L*W-1:0] exp_re = '0, exp_im = '0;
    logic           exp_v  = 1'b0;

    always #4 clk = ~clk;

    r4bf_node #(.OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .valid_in(valid_in),
        .t_re(t_re), .t_im(t_im), .k_re(k_re), .k_im(k_im),
        .valid_out(valid_out), .z_re(z_re), .z_im(z_im)
    );

    r4bf_node #(.OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .valid_in(valid_in),
        .t_re(t_re), .t_im(t_im), .k_re(k_re), .k_im(k_im),
        .valid_out(valid_out_c), .z_re(zc_re), .z_im(zc_im)
    );

    // Behavioural reference: integer maths straight from the equations
    function automatic longint rnd15(input longint p);
        return (p + 16384) >>> 15;
    endfunction

    function automatic void ref_bfly(
        input  logic [L*W-1:0] tr, ti, kr, ki,
        output logic [L*W-1:0] orr, oi);
        longint mr[4], mi[4], yr[4], yi[4], zr[4], zi[4];
        longint dr, di;
        for (int n = 0; n < 4; n++) begin
            longint a, b, c, d;
            a = longint'($signed(kr[n*W +: W]));
            b = longint'($signed(ki[n*W +: W]));
            c = longint'($signed(tr[n*W +: W]));
            d = longint'($signed(ti[n*W +: W]));
            mr[n] = rnd15(a * c - b * d);
            mi[n] = rnd15(a * d + b * c);
        end
        yr[0] = mr[0] + mr[2];  yi[0] = mi[0] + mi[2];
        yr[1] = mr[0] - mr[2];  yi[1] = mi[0] - mi[2];
        yr[2] = mr[1] + mr[3];  yi[2] = mi[1] + mi[3];
        dr = mr[1] - mr[3];     di = mi[1] - mi[3];
        yr[3] = -di;            yi[3] = dr;
        zr[0] = yr[0] + yr[2];  zi[0] = yi[0] + yi[2];
        zr[1] = yr[1] + yr[3];  zi[1] = yi[1] + yi[3];
        zr[2] = yr[0] - yr[2];  zi[2] = yi[0] - yi[2];
        zr[3] = yr[1] - yr[3];  zi[3] = yi[1] - yi[3];
        for (int n = 0; n < 4; n++) begin
            longint sr, si;
            sr = zr[n] >>> 2;
            si = zi[n] >>> 2;
            orr[n*W +: W] = sr[W-1:0];
            oi[n*W +: W]  = si[W-1:0];
        end
    endfunction

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [2*L*W:0] act, input logic [2*L*W:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply one input set at a negedge, check the combinational instance,
    // advance one clock, then check the registered instance.
    task automatic step(input string tag, input logic v,
                        input logic [L*W-1:0] tr, ti, kr, ki);
        logic [L*W-1:0] er, ei;
        valid_in = v; t_re = tr; t_im = ti; k_re = kr; k_im = ki;
        ref_bfly(tr, ti, kr, ki, er, ei);
        #1;
        if (v)
            check("R9", valid_out_c === 1'b1 && zc_re === er && zc_im === ei,
                  "comb", {valid_out_c, zc_re, zc_im}, {1'b1, er, ei});
        @(posedge clk);
        exp_v = v;
        if (v) begin exp_re = er; exp_im = ei; end
        @(negedge clk);
        check(tag, valid_out === exp_v && z_re === exp_re && z_im === exp_im,
              "reg", {valid_out, z_re, z_im}, {exp_v, exp_re, exp_im});
    endtask

    function automatic logic [L*W-1:0] lanes(input int a, b, c, d);
        logic [L*W-1:0] r;
        r[0*W +: W] = a[W-1:0]; r[1*W +: W] = b[W-1:0];
        r[2*W +: W] = c[W-1:0]; r[3*W +: W] = d[W-1:0];
        return r;
    endfunction

    localparam int ONE = 32767;

    initial begin : watchdog
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check("R8", valid_out === 1'b0 && z_re === '0 && z_im === '0,
              "reset", {valid_out, z_re, z_im}, '0);

        // R1: single lane 0, rounding at half points and negatives
        step("R1", 1, lanes(3, 0, 0, 0), lanes(0, 0, 0, 0),
             lanes(16384, 0, 0, 0), lanes(0, 0, 0, 0));
        step("R1", 1, lanes(-3, 0, 0, 0), lanes(5, 0, 0, 0),
             lanes(16384, 0, 0, 0), lanes(-16384, 0, 0, 0));
        step("R1", 1, lanes(1000, 0, 0, 0), lanes(-2000, 0, 0, 0),
             lanes(-23170, 0, 0, 0), lanes(23170, 0, 0, 0));
        // R2: lanes 0 and 2 only
        step("R2", 1, lanes(4000, 0, -800, 0), lanes(1200, 0, 600, 0),
             lanes(ONE, 0, ONE, 0), lanes(0, 0, 0, 0));
        // R3: lanes 1 and 3 only, exposes the j rotation
        step("R3", 1, lanes(0, 4000, 0, 1000), lanes(0, -400, 0, 2400),
             lanes(0, ONE, 0, ONE), lanes(0, 0, 0, 0));
        step("R3", 1, lanes(0, 0, 0, 8000), lanes(0, 0, 0, 0),
             lanes(0, 0, 0, ONE), lanes(0, 0, 0, 0));
        // R4: all four lanes distinct to expose output order
        step("R4", 1, lanes(1000, 2000, 3000, 4000), lanes(-500, 700, -900, 1100),
             lanes(ONE, 0, -ONE, 0), lanes(0, ONE, 0, -ONE));
        // R5: extremes that stay in range, and floor of negatives
        step("R5", 1, lanes(-32768, -32768, -32768, -32768), lanes(0, 0, 0, 0),
             lanes(ONE, ONE, ONE, ONE), lanes(0, 0, 0, 0));
        step("R5", 1, lanes(32767, 32767, 32767, 32767), lanes(32767, -32768, 1, -1),
             lanes(ONE, -ONE, ONE, -ONE), lanes(0, 0, 0, 0));
        step("R5", 1, lanes(-1, 0, 0, 0), lanes(-3, 0, 0, 0),
             lanes(ONE, 0, 0, 0), lanes(0, 0, 0, 0));
        // R7: idle cycles must hold the last result with fresh inputs
        step("R7", 0, lanes(111, 222, 333, 444), lanes(5, 6, 7, 8),
             lanes(ONE, ONE, ONE, ONE), lanes(1, 2, 3, 4));
        step("R7", 0, lanes(-9, 9, -9, 9), lanes(0, 0, 0, 0),
             lanes(100, 200, 300, 400), lanes(0, 0, 0, 0));
        // R6: valid follows by one cycle, back-to-back then a gap
        step("R6", 1, lanes(700, -700, 70, -70), lanes(1, 2, 3, 4),
             lanes(20000, 20000, 20000, 20000), lanes(-9000, 9000, 0, 1));
        step("R6", 1, lanes(9, 8, 7, 6), lanes(5, 4, 3, 2),
             lanes(ONE, ONE, ONE, ONE), lanes(ONE, ONE, ONE, ONE));
        step("R6", 0, '0, '0, '0, '0);
        // R4: random full-range transfers
        for (int i = 0; i < 200; i++) begin
            step("R4", ($urandom % 4) != 0,
                 {$urandom, $urandom}, {$urandom, $urandom},
                 {$urandom, $urandom}, {$urandom, $urandom});
        end
        // R8: reset in the middle of traffic
        valid_in = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        valid_in = 1'b0;
        exp_v = 1'b0; exp_re = '0; exp_im = '0;
        check("R8", valid_out === 1'b0 && z_re === '0 && z_im === '0,
              "mid reset", {valid_out, z_re, z_im}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule